// File: doc/BRIEF.md
# Dual-Channel Time-Slot Voice Port

This block is the serial side of a two-channel voice line interface on an ISDN-style General Circuit Interface. It runs entirely on the bit clock and uses no other clock. An 8 kHz frame-sync pulse aligns it to the frame. Every data bit occupies a cell of two bit-clock cycles. In one programmable 16-bit time slot per frame, the block sends two 8-bit PCM samples on its transmit line and captures two 8-bit samples from its receive line. The first byte of the slot is the B1 half and the second byte is the B2 half.

A swap input decides which local channel uses B1 and which uses B2. A 5-bit slot selector picks the slot. A rate input tells the block whether the bit clock runs at 4.096 MHz, which gives 16 slots of 32 clock cycles in a 512-cycle frame, or at 2.048 MHz, which gives 8 slots in a 256-cycle frame. Outside its slot the block releases the transmit line, shown by a low output enable. At the end of the slot it presents the received pair of bytes together with a single-cycle strobe.

The block is controlled by a three-state machine:
- `ST_HUNT` holds from reset until the first frame-sync rising edge is seen (transition `T_LOCK`).
- `ST_IDLE` covers the aligned frame outside the chosen slot. It moves to `ST_SLOT` when the next cycle starts the chosen slot (transition `T_ENTER`).
- `ST_SLOT` covers the 32 cycles of the slot. It returns to `ST_IDLE` when the next cycle falls outside the slot (transition `T_LEAVE`).

`T_LOCK` goes straight to `ST_SLOT` when slot 0 is selected.

Top module: `gci_slot_port`

## Requirements
- R1: After reset, and until the first rising edge of `frame_sync` is sampled, `tx_oe` and `rx_valid` stay low whatever the other inputs do.
- R2: The cycle that follows the clock edge sampling a `frame_sync` rising edge is cycle 0 of the frame, which is the first cycle of bit 0 of slot 0. A new rising edge restarts this count at any point, including in the middle of a frame.
- R3: Each data bit lasts two clock cycles. `tx_line` changes only at the first cycle of a cell. The slot is sent MSB first.
- R4: When `rate_hi`=1 and `slot_sel`=S with S<16, `tx_oe` is high exactly in frame cycles 32·S to 32·S+31.
- R5: When `swap_sel`=0, the first 8 bits of the slot (B1) carry channel 0 and the last 8 bits (B2) carry channel 1, in both directions.
- R6: When `swap_sel`=1, B1 carries channel 1 and B2 carries channel 0, in both directions.
- R7: `tx_ch0` and `tx_ch1` are captured at the same edge that samples the frame-sync rising edge. Later changes within the frame do not alter what is sent.
- R8: `rx_line` is sampled at the clock edge that ends the first cycle of each cell in the slot. `rx_valid` is high for one cycle only, in frame cycle 32·S+31, with `rx_ch0` and `rx_ch1` mapped as in R5 and R6.
- R9: When `rate_hi`=0 the frame has 8 slots of 32 cycles, and slots 0 to 7 behave as in R4.
- R10: If `slot_sel` is at or above the slot count (16, or 8 when `rate_hi`=0), `tx_oe` and `rx_valid` never go high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock; the only timing source |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_sync | input | 1 | 8 kHz frame pulse, one clock period high |
| rate_hi | input | 1 | 1: 16-slot frame (4.096 MHz); 0: 8-slot frame (2.048 MHz) |
| swap_sel | input | 1 | 0: channel 0 on B1; 1: channel 0 on B2 |
| slot_sel | input | 5 | Selected time slot |
| tx_ch0 | input | 8 | Channel 0 sample to send |
| tx_ch1 | input | 8 | Channel 1 sample to send |
| rx_line | input | 1 | Serial receive data |
| tx_line | output | 1 | Serial transmit data, meaningful while `tx_oe` is high |
| tx_oe | output | 1 | Transmit drive enable, high only inside the slot |
| rx_ch0 | output | 8 | Received channel 0 sample |
| rx_ch1 | output | 8 | Received channel 1 sample |
| rx_valid | output | 1 | One-cycle strobe marking new receive samples |

## Verification
The embedded properties assume three things about the inputs:
- `frame_sync` pulses are spaced at least one full slot apart.
- `slot_sel` changes only alongside a frame-sync pulse.
- `swap_sel` changes only alongside a frame-sync pulse.

The bench meets these assumptions:
- It changes the configuration inputs only in the cycle where it raises the pulse.
- It cuts a frame short only well past any slot's first cell.
- It drives all inputs half a clock away from the sampling edge.

Within these limits, the bench sweeps every slot at both rates and alternates the channel swap. It also selects out-of-range slots and sends a truncated frame, checking every cycle against the cycle position computed from the pulse.

// File: rtl/gci_pkg.sv
package gci_pkg;
    typedef enum logic [1:0] {
        ST_HUNT = 2'd0,
        ST_IDLE = 2'd1,
        ST_SLOT = 2'd2
    } gci_state_t;
endpackage

// File: rtl/gci_frame_timer.sv
module gci_frame_timer
    import gci_pkg::*;
#(
    parameter int CNT_W     = 9,
    parameter int BIT_W     = 4,
    parameter int SEL_W     = 5,
    parameter int MAX_SLOTS = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_sync,
    input  logic             rate_hi,
    input  logic [SEL_W-1:0] slot_sel,
    output logic             fs_rise,
    output logic [CNT_W-1:0] cnt,
    output logic             in_slot,
    output logic             sample_en,
    output logic             slot_done
);
    localparam int IDX_W = CNT_W - BIT_W - 1;
    localparam logic [SEL_W:0] SLOTS_HI = (SEL_W+1)'(MAX_SLOTS);
    localparam logic [SEL_W:0] SLOTS_LO = (SEL_W+1)'(MAX_SLOTS / 2);

    logic             fs_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_d;
    gci_state_t       st_q;
    gci_state_t       st_d;
    logic [SEL_W:0]   slot_lim;
    logic             slot_ok;
    logic [IDX_W-1:0] next_idx;
    logic             hit;

    assign fs_rise = frame_sync & ~fs_q;

    always_comb begin
        cnt_d    = fs_rise ? '0 : cnt_q + CNT_W'(1);
        slot_lim = rate_hi ? SLOTS_HI : SLOTS_LO;
        slot_ok  = {1'b0, slot_sel} < slot_lim;
        next_idx = cnt_d[CNT_W-1 -: IDX_W];
        hit      = slot_ok && (next_idx == slot_sel[IDX_W-1:0]);
    end

    // Transitions: T_LOCK, T_ENTER, T_LEAVE
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_HUNT: if (fs_rise) st_d = hit ? ST_SLOT : ST_IDLE;
            ST_IDLE: if (hit)     st_d = ST_SLOT;
            ST_SLOT: if (!hit)    st_d = ST_IDLE;
            default:              st_d = ST_HUNT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fs_q  <= 1'b0;
            cnt_q <= '0;
            st_q  <= ST_HUNT;
        end else begin
            fs_q  <= frame_sync;
            cnt_q <= cnt_d;
            st_q  <= st_d;
        end
    end

    always_comb begin
        cnt       = cnt_q;
        in_slot   = (st_q == ST_SLOT);
        sample_en = in_slot & ~cnt_q[0];
        slot_done = sample_en & (&cnt_q[BIT_W:1]);
    end

    AST_SLOT_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(in_slot) |-> (cnt_q[BIT_W:0] == '0)); // R4
endmodule

// File: rtl/gci_tx_path.sv
module gci_tx_path #(
    parameter int BYTE_W = 8,
    parameter int BIT_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              latch,
    input  logic              swap,
    input  logic [BYTE_W-1:0] ch0,
    input  logic [BYTE_W-1:0] ch1,
    input  logic              in_slot,
    input  logic              odd_phase,
    input  logic [BIT_W-1:0]  bit_idx,
    output logic              tx_line,
    output logic              tx_oe
);
    localparam int SLOT_W = 2 * BYTE_W;

    logic [SLOT_W-1:0] shadow_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shadow_q <= '0;
        end else if (latch) begin
            shadow_q <= swap ? {ch1, ch0} : {ch0, ch1};
        end
    end

    always_comb begin
        tx_oe   = in_slot;
        tx_line = in_slot ? shadow_q[~bit_idx] : 1'b0;
    end

    AST_TX_CELL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_oe && odd_phase) |-> $stable(tx_line)); // R3
endmodule

// File: rtl/gci_rx_path.sv
module gci_rx_path #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sample_en,
    input  logic              slot_done,
    input  logic              swap,
    input  logic              rx_line,
    output logic [BYTE_W-1:0] rx_ch0,
    output logic [BYTE_W-1:0] rx_ch1,
    output logic              rx_valid
);
    localparam int SLOT_W = 2 * BYTE_W;

    logic [SLOT_W-2:0] shift_q;
    logic [SLOT_W-1:0] word;

    assign word = {shift_q, rx_line};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shift_q  <= '0;
            rx_ch0   <= '0;
            rx_ch1   <= '0;
            rx_valid <= 1'b0;
        end else begin
            rx_valid <= slot_done;
            if (sample_en) shift_q <= word[SLOT_W-2:0];
            if (slot_done) begin
                rx_ch0 <= swap ? word[BYTE_W-1:0] : word[SLOT_W-1:BYTE_W];
                rx_ch1 <= swap ? word[SLOT_W-1:BYTE_W] : word[BYTE_W-1:0];
            end
        end
    end

    AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid); // R8
endmodule

// File: rtl/gci_slot_port.sv
module gci_slot_port #(
    parameter int BYTE_W    = 8,
    parameter int MAX_SLOTS = 16,
    parameter int SEL_W     = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_sync,
    input  logic              rate_hi,
    input  logic              swap_sel,
    input  logic [SEL_W-1:0]  slot_sel,
    input  logic [BYTE_W-1:0] tx_ch0,
    input  logic [BYTE_W-1:0] tx_ch1,
    input  logic              rx_line,
    output logic              tx_line,
    output logic              tx_oe,
    output logic [BYTE_W-1:0] rx_ch0,
    output logic [BYTE_W-1:0] rx_ch1,
    output logic              rx_valid
);
    localparam int SLOT_W = 2 * BYTE_W;
    localparam int BIT_W  = $clog2(SLOT_W);
    localparam int CNT_W  = $clog2(MAX_SLOTS * SLOT_W * 2);

    logic             fs_rise;
    logic [CNT_W-1:0] cnt;
    logic             in_slot;
    logic             sample_en;
    logic             slot_done;

    gci_frame_timer #(
        .CNT_W(CNT_W), .BIT_W(BIT_W), .SEL_W(SEL_W), .MAX_SLOTS(MAX_SLOTS)
    ) u_timer (
        .clk(clk), .rst_n(rst_n), .frame_sync(frame_sync), .rate_hi(rate_hi),
        .slot_sel(slot_sel), .fs_rise(fs_rise), .cnt(cnt), .in_slot(in_slot),
        .sample_en(sample_en), .slot_done(slot_done)
    );

    gci_tx_path #(.BYTE_W(BYTE_W), .BIT_W(BIT_W)) u_tx (
        .clk(clk), .rst_n(rst_n), .latch(fs_rise), .swap(swap_sel),
        .ch0(tx_ch0), .ch1(tx_ch1), .in_slot(in_slot), .odd_phase(cnt[0]),
        .bit_idx(cnt[BIT_W:1]), .tx_line(tx_line), .tx_oe(tx_oe)
    );

    gci_rx_path #(.BYTE_W(BYTE_W)) u_rx (
        .clk(clk), .rst_n(rst_n), .sample_en(sample_en), .slot_done(slot_done),
        .swap(swap_sel), .rx_line(rx_line), .rx_ch0(rx_ch0), .rx_ch1(rx_ch1),
        .rx_valid(rx_valid)
    );

    AST_VALID_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> tx_oe); // R8
    AST_BAD_SLOT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_sel >= SEL_W'(MAX_SLOTS)) |=> !tx_oe); // R10
endmodule

// File: tb/test_gci_slot_port.sv
module test_gci_slot_port;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       frame_sync = 1'b0;
    logic       rate_hi = 1'b1;
    logic       swap_sel = 1'b0;
    logic [4:0] slot_sel = '0;
    logic [7:0] tx_ch0 = '0;
    logic [7:0] tx_ch1 = '0;
    logic       rx_line = 1'b0;
    logic       tx_line, tx_oe, rx_valid;
    logic [7:0] rx_ch0, rx_ch1;

    int    n_chk = 0;
    int    n_bad = 0;
    int    e_slot = 0;
    bit    e_rate = 1'b1;
    bit    e_swap = 1'b0;
    logic [15:0] e_txw = '0;
    logic [15:0] e_rxw = '0;
    string e_tag = "R1";

    always #10 clk = ~clk;

    gci_slot_port i_gci_slot_port (
        .clk(clk), .rst_n(rst_n), .frame_sync(frame_sync), .rate_hi(rate_hi),
        .swap_sel(swap_sel), .slot_sel(slot_sel), .tx_ch0(tx_ch0), .tx_ch1(tx_ch1),
        .rx_line(rx_line), .tx_line(tx_line), .tx_oe(tx_oe), .rx_ch0(rx_ch0),
        .rx_ch1(rx_ch1), .rx_valid(rx_valid)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic drive_rx(input int c);
        if ((c >> 5) == e_slot) rx_line = e_rxw[15 - ((c & 31) >> 1)];
        else                    rx_line = 1'((c ^ (c >> 3)) & 1);
    endtask

    task automatic check_cycle(input int c);
        int   nsl  = e_rate ? 16 : 8;
        bit   win  = (e_slot < nsl) && ((c >> 5) == e_slot);
        bit   vexp = win && ((c & 31) == 31);
        logic txe;
        logic [7:0] x0, x1;
        chk(tx_oe === win, e_tag, "tx_oe", int'(tx_oe), int'(win));
        if (win) begin
            // R3: MSB first, bit index = cycle-in-slot / 2
            txe = e_txw[15 - ((c & 31) >> 1)];
            chk(tx_line === txe, (c > 2) ? "R7" : "R3", "tx_line", int'(tx_line), int'(txe));
        end
        chk(rx_valid === vexp, win ? "R8" : e_tag, "rx_valid", int'(rx_valid), int'(vexp));
        if (vexp) begin
            x0 = e_swap ? e_rxw[7:0]  : e_rxw[15:8];
            x1 = e_swap ? e_rxw[15:8] : e_rxw[7:0];
            chk(rx_ch0 === x0, e_swap ? "R6" : "R5", "rx_ch0", int'(rx_ch0), int'(x0));
            chk(rx_ch1 === x1, e_swap ? "R6" : "R5", "rx_ch1", int'(rx_ch1), int'(x1));
        end
    endtask

    task automatic run_frame(input bit rate, input int slot, input bit swap, input int len,
                             input string tag, input logic [7:0] a, input logic [7:0] b,
                             input logic [15:0] rw);
        rate_hi    = rate;
        slot_sel   = 5'(slot);
        swap_sel   = swap;
        tx_ch0     = a;
        tx_ch1     = b;
        frame_sync = 1'b1;
        e_rate = rate; e_slot = slot; e_swap = swap; e_tag = tag; e_rxw = rw;
        e_txw  = swap ? {b, a} : {a, b};
        @(negedge clk);
        frame_sync = 1'b0;
        for (int c = 0; c < len; c++) begin
            drive_rx(c);
            check_cycle(c);
            if (c == 2) begin
                tx_ch0 = ~a;   // R7: must not reach the line this frame
                tx_ch1 = ~b;
            end
            if (c < len - 1) @(negedge clk);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        #(20 * 100000);
        n_chk++;
        n_bad++;
        $display("FAIL R1 watchdog expired");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(tx_oe === 1'b0 && rx_valid === 1'b0, "R1", "reset outputs",
            int'({tx_oe, rx_valid}), 0);
        rst_n = 1'b1;
        // R1: no frame pulse yet, busy receive line, slot 0 selected
        for (int c = 0; c < 600; c++) begin
            rx_line = 1'(c & 1);
            @(negedge clk);
            chk(tx_oe === 1'b0, "R1", "tx_oe hunt", int'(tx_oe), 0);
            chk(rx_valid === 1'b0, "R1", "rx_valid hunt", int'(rx_valid), 0);
        end
        // R4/R5/R6: every slot at the fast rate
        for (int s = 0; s < 16; s++)
            run_frame(1'b1, s, 1'((s >> 1) & 1), 512, "R4",
                      8'(8'hA1 + s * 13), 8'(8'h5E ^ (s * 29)),
                      16'(16'hC35A ^ (s * 16'h0F1D)));
        // R9: every slot at the slow rate
        for (int s = 0; s < 8; s++)
            run_frame(1'b0, s, 1'(~s & 1), 256, "R9",
                      8'(8'h3C + s * 37), 8'(8'hF0 - s * 11),
                      16'(16'h9A65 + s * 16'h1357));
        // R10: out-of-range slot codes
        run_frame(1'b1, 16, 1'b0, 512, "R10", 8'hFF, 8'h00, 16'hFFFF);
        run_frame(1'b1, 31, 1'b1, 512, "R10", 8'h5A, 8'hA5, 16'hAAAA);
        run_frame(1'b0, 8,  1'b0, 256, "R10", 8'h12, 8'h34, 16'h5555);
        run_frame(1'b0, 15, 1'b1, 256, "R10", 8'h77, 8'h88, 16'h0F0F);
        // R2: frame cut short inside slot 1, then realigned frames
        run_frame(1'b1, 1, 1'b1, 40,  "R2", 8'hC1, 8'h1C, 16'hBEEF);
        run_frame(1'b1, 1, 1'b0, 512, "R2", 8'h96, 8'h69, 16'h1234);
        run_frame(1'b1, 0, 1'b1, 512, "R2", 8'h80, 8'h01, 16'h8001);
        summary();
        $finish;
    end
endmodule